// File: doc/BRIEF.md
# Gated Pulse Accumulator

This block is an 8-bit accumulator that measures activity on one external input. It runs in one of two modes. In event mode it adds one for every chosen transition of the input. In gated mode the input acts as a gate, and the counter advances on a chosen count clock only while the gate sits at its open level.

The count clock for gated mode is picked from four sources:
- the system clock divided by 512;
- a tick strobe that advances a free-running timer outside this block;
- that timer's overflow strobe;
- rising edges of a second external pin.

Both external pins are synchronized before use. The counter can be read and written from a small register port. A wrap past 0xFF raises a sticky flag that software clears.

A control state machine sets when counting may happen. It has four states:
- `ST_OFF`: counting disabled.
- `ST_EDGE`: event mode.
- `ST_OPEN`: gated mode, gate open.
- `ST_SHUT`: gated mode, gate closed.

Each clock it moves to one of these states, in this order of priority:
- Enable clear takes it to `ST_OFF`.
- Enable set with mode 0 takes it to `ST_EDGE`.
- Enable set with mode 1 takes it to `ST_OPEN` when the synchronized gate level differs from the polarity bit, and to `ST_SHUT` otherwise.

Top module: `pacc_top`

## Requirements
- R1: After reset, the control register, the counter and the overflow flag all read zero.
- R2: With mode=0 and polarity=0, each falling transition of `acc_in` adds one to the counter.
- R3: With mode=0 and polarity=1, each rising transition of `acc_in` adds one to the counter.
- R4: With mode=1, a low `acc_in` blocks counting when polarity=0, and a high `acc_in` blocks counting when polarity=1. At the other level, every pulse of the selected count clock adds one.
- R5: Clock select 00 counts a prescaler pulse that occurs once every 512 system clocks. An open window of 1024 clocks adds exactly 2.
- R6: Clock select 01 counts each `tmr_tick` pulse.
- R7: Clock select 10 counts each `tmr_ovf` pulse and ignores `tmr_tick`.
- R8: Clock select 11 counts each rising edge of `ext_clk`.
- R9: The counter at address 1 reads back the value last written. A counter write in the same cycle as an increment wins.
- R10: When an increment takes the counter from 0xFF to 0x00, the overflow flag is set. The flag is visible on `ovf_flag` and in status bit 0. It stays set until a write to address 2 with data bit 0 = 1. Setting wins over clearing in the same cycle.
- R11: Status bit 1 at address 2 shows the synchronized level of `ext_clk`.
- R12: While the enable bit is 0, the counter does not change except by a bus write.
- R13: The register map is as follows. Address 0 is control: bit 0 enable, bit 1 mode, bit 2 polarity, bits 4:3 clock select. Address 1 is the counter. Address 2 is status: bit 0 overflow flag, bit 1 external clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| acc_in | input | 1 | Asynchronous accumulator input (events or gate) |
| ext_clk | input | 1 | Asynchronous external count clock |
| tmr_tick | input | 1 | One-cycle strobe that advances the external timer |
| tmr_ovf | input | 1 | One-cycle strobe at the external timer's overflow |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
In event mode, `acc_in` is driven as trains with an odd or even number of transitions, starting from either level. The rising and falling counts then differ, which separates polarity 0 from polarity 1 and catches a swapped edge detector. In gated mode, the same `tmr_tick` burst is sent with the gate held at each level under each polarity, so an inverted gate sense shows up as a count of zero against a full count. A tick burst sent under clock select 10 shows whether the source multiplexer is wrong. A 1024-clock window checks the divide ratio exactly, and a write that lands in the same cycle as a tick checks the priority rule.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int CNT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        CS_DIV512 = 2'b00,
        CS_TICK   = 2'b01,
        CS_OVF    = 2'b10,
        CS_EXT    = 2'b11
    } clksel_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_EDGE,
        ST_OPEN,
        ST_SHUT
    } pstate_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic lvl_prev
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= pipe[STAGES-1];
    end

    assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int DIV_BITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    logic [DIV_BITS-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign pulse = &div_q;

    assert_div_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
    import pacc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    mode,
    input  logic    pol,
    input  clksel_e csel,
    input  logic    acc_lvl,
    input  logic    acc_prev,
    input  logic    ext_lvl,
    input  logic    ext_prev,
    input  logic    pre_pulse,
    input  logic    tmr_tick,
    input  logic    tmr_ovf,
    output logic    inc
);
    pstate_e state_q, state_d;
    logic    evt_hit;
    logic    src_pulse;

    always_comb begin
        if (!en)                  state_d = ST_OFF;
        else if (!mode)           state_d = ST_EDGE;
        else if (acc_lvl != pol)  state_d = ST_OPEN;
        else                      state_d = ST_SHUT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        evt_hit = pol ? (acc_lvl & ~acc_prev) : (~acc_lvl & acc_prev);
        unique case (csel)
            CS_DIV512: src_pulse = pre_pulse;
            CS_TICK:   src_pulse = tmr_tick;
            CS_OVF:    src_pulse = tmr_ovf;
            CS_EXT:    src_pulse = ext_lvl & ~ext_prev;
            default:   src_pulse = 1'b0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OFF:  inc = 1'b0;
            ST_EDGE: inc = evt_hit;
            ST_OPEN: inc = src_pulse;
            ST_SHUT: inc = 1'b0;
            default: inc = 1'b0;
        endcase
    end

    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !inc);
    assert_shut_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHUT) |-> !inc);
    assert_off_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_OFF));
endmodule

// File: rtl/pacc_count.sv
module pacc_count
    import pacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic wrap;

    assign wrap = inc && !wr && (&cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr)       cnt <= wdata;
            else if (inc) cnt <= cnt + 1'b1;
            if (wrap)     flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wdata)));
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(cnt));
    assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && cnt == '1) |=> (flag && cnt == '0));
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_BITS    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_in,
    input  logic              ext_clk,
    input  logic              tmr_tick,
    input  logic              tmr_ovf,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              ovf_flag
);
    logic       en_q, mode_q, pol_q;
    clksel_e    csel_q;
    logic       acc_lvl, acc_prev, ext_lvl, ext_prev;
    logic       pre_pulse, inc;
    logic       cnt_wr, flag_clr;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            pol_q  <= 1'b0;
            csel_q <= CS_DIV512;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            en_q   <= bus_wdata[0];
            mode_q <= bus_wdata[1];
            pol_q  <= bus_wdata[2];
            csel_q <= clksel_e'(bus_wdata[4:3]);
        end
    end

    assign cnt_wr   = bus_wr && (bus_addr == A_CNT);
    assign flag_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    pacc_sync #(.STAGES(SYNC_STAGES)) u_acc_sync (
        .clk(clk), .rst_n(rst_n), .din(acc_in),
        .lvl(acc_lvl), .lvl_prev(acc_prev));

    pacc_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_clk),
        .lvl(ext_lvl), .lvl_prev(ext_prev));

    pacc_prescale #(.DIV_BITS(DIV_BITS)) u_pre (
        .clk(clk), .rst_n(rst_n), .pulse(pre_pulse));

    pacc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .pol(pol_q),
        .csel(csel_q), .acc_lvl(acc_lvl), .acc_prev(acc_prev),
        .ext_lvl(ext_lvl), .ext_prev(ext_prev), .pre_pulse(pre_pulse),
        .tmr_tick(tmr_tick), .tmr_ovf(tmr_ovf), .inc(inc));

    pacc_count u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wr(cnt_wr),
        .wdata(bus_wdata), .clr(flag_clr), .cnt(cnt), .flag(ovf_flag));

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {3'b000, csel_q, pol_q, mode_q, en_q};
            A_CNT:   bus_rdata = cnt;
            A_STAT:  bus_rdata = {6'b000000, ext_lvl, ovf_flag};
            default: bus_rdata = '0;
        endcase
    end

    assert_ctrl_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!en_q && !mode_q && !pol_q));
endmodule

// File: tb/sim_pacc_top.sv
module sim_pacc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_in = 1'b0;
    logic       ext_clk = 1'b0;
    logic       tmr_tick = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ovf_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pacc_top u0 (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .ext_clk(ext_clk),
        .tmr_tick(tmr_tick), .tmr_ovf(tmr_ovf), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_flag(ovf_flag));

    // {mode, polarity, start level, transitions-or-ticks[3:0], expected[7:0]}
    localparam int NVEC = 8;
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 4'd5, 8'd2},  // R2 falls in 0->1 x5
        {1'b0, 1'b1, 1'b0, 4'd5, 8'd3},  // R3 rises in 0->1 x5
        {1'b0, 1'b0, 1'b1, 4'd4, 8'd2},  // R2 falls from level 1
        {1'b0, 1'b1, 1'b1, 4'd3, 8'd1},  // R3 rises from level 1
        {1'b1, 1'b0, 1'b1, 4'd6, 8'd6},  // R4 open high
        {1'b1, 1'b0, 1'b0, 4'd6, 8'd0},  // R4 low inhibits
        {1'b1, 1'b1, 1'b0, 4'd7, 8'd7},  // R4 open low
        {1'b1, 1'b1, 1'b1, 4'd7, 8'd0}   // R4 high inhibits
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tmr_tick = 1'b1;
            @(negedge clk); tmr_tick = 1'b0;
        end
    endtask

    task automatic ovf_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tmr_ovf = 1'b1;
            @(negedge clk); tmr_ovf = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        bread(2'd0, r); chk("R1 ctrl", r, 8'h00);
        bread(2'd1, r); chk("R1 counter", r, 8'h00);
        bread(2'd2, r); chk("R1 status", r, 8'h00);
        chk("R1 ovf_flag", {7'd0, ovf_flag}, 8'h00);

        // vector table: R2 R3 R4 with clock select 01 (R6)
        for (int v = 0; v < NVEC; v++) begin
            logic m, p, l;
            int n;
            logic [7:0] e;
            {m, p, l} = VEC[v][14:12];
            n = int'(VEC[v][11:8]);
            e = VEC[v][7:0];
            acc_in = l;
            bwrite(2'd0, {3'b000, 2'b01, p, m, 1'b1});
            wait_n(6);
            bwrite(2'd1, 8'h00);
            if (!m) begin
                for (int t = 0; t < n; t++) begin
                    acc_in = ~acc_in;
                    wait_n(4);
                end
            end else begin
                tick(n);
            end
            wait_n(6);
            bread(2'd1, r);
            chk(m ? "R4/R6 gated vector" : "R2/R3 event vector", r, e);
        end

        // R13 control readback
        bwrite(2'd0, 8'b000_10_1_1_1);
        bread(2'd0, r); chk("R13 ctrl readback", r, 8'h17);

        // R12 enable clear: edges ignored
        acc_in = 1'b0;
        bwrite(2'd0, 8'b000_01_1_0_0);
        bwrite(2'd1, 8'h33);
        for (int t = 0; t < 4; t++) begin acc_in = ~acc_in; wait_n(4); end
        tick(3);
        wait_n(4);
        bread(2'd1, r); chk("R12 disabled holds", r, 8'h33);

        // R9 readback and write priority over a same-cycle tick
        acc_in = 1'b1;
        bwrite(2'd0, 8'b000_01_0_1_1);
        wait_n(6);
        bwrite(2'd1, 8'h5A);
        bread(2'd1, r); chk("R9 readback", r, 8'h5A);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40; tmr_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tmr_tick = 1'b0;
        bread(2'd1, r); chk("R9 write beats tick", r, 8'h40);

        // R7 overflow strobe counted, tick ignored
        bwrite(2'd0, 8'b000_10_0_1_1);
        bwrite(2'd1, 8'h00);
        tick(3);
        ovf_pulse(2);
        wait_n(2);
        bread(2'd1, r); chk("R7 ovf source", r, 8'h02);

        // R8 external clock rising edges
        bwrite(2'd0, 8'b000_11_0_1_1);
        wait_n(4);
        bwrite(2'd1, 8'h00);
        for (int t = 0; t < 4; t++) begin
            ext_clk = 1'b1; wait_n(3);
            ext_clk = 1'b0; wait_n(3);
        end
        wait_n(4);
        bread(2'd1, r); chk("R8 ext edges", r, 8'h04);

        // R11 status level of ext_clk
        ext_clk = 1'b1; wait_n(4);
        bread(2'd2, r); chk("R11 ext level high", r & 8'h02, 8'h02);
        ext_clk = 1'b0; wait_n(4);
        bread(2'd2, r); chk("R11 ext level low", r & 8'h02, 8'h00);

        // R5 divide-by-512 over a 1024-clock open window
        acc_in = 1'b0;
        bwrite(2'd0, 8'b000_00_0_1_1);
        wait_n(6);
        bwrite(2'd1, 8'h00);
        @(negedge clk); acc_in = 1'b1;
        wait_n(1024);
        acc_in = 1'b0;
        wait_n(6);
        bread(2'd1, r); chk("R5 div512 count", r, 8'h02);

        // R10 wrap sets sticky flag, write-one clears
        acc_in = 1'b1;
        bwrite(2'd0, 8'b000_01_0_1_1);
        wait_n(6);
        bwrite(2'd1, 8'hFE);
        tick(2);
        wait_n(1);
        bread(2'd1, r); chk("R10 wrapped to zero", r, 8'h00);
        chk("R10 ovf_flag set", {7'd0, ovf_flag}, 8'h01);
        tick(1);
        bwrite(2'd2, 8'h00);
        bread(2'd2, r); chk("R10 flag sticky", r & 8'h01, 8'h01);
        bwrite(2'd2, 8'h01);
        bread(2'd2, r); chk("R10 flag cleared", r & 8'h01, 8'h00);
        chk("R10 ovf_flag cleared", {7'd0, ovf_flag}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule